// File: doc/BRIEF.md
# Thumbwheel-Programmed BFO Frequency Divider

This block is the digital part of a beat-frequency-oscillator synthesizer loop. It runs on the squared-up VCO signal and divides it by a ratio N, which the operator sets on three thumbwheel digits: a sign digit, a units digit and a tenths digit. Together they give a signed offset, in tenths of a kHz, around a fixed centre ratio of 4550. For example, a setting of plus 5.4 gives N = 4604. N is never loaded as a binary modulus. It is applied by presetting a chain of BCD down-counting digit stages. When the chain reaches zero, the stages reload together and a registered end-of-cycle pulse goes out, once every N VCO clocks. When the loop is locked at N kHz, this pulse runs at 1 kHz.

A Johnson counter divides the same VCO clock by ten to give the BFO output, with an even duty cycle. A digital phase-frequency comparator sets its pump-up and pump-down flags from a fixed 1 kHz reference pulse and from the end-of-cycle pulse. The charge pump, the loop filter and the oscillator lie outside the block.

Top module: `bfoDivider`

## Requirements
- R1: With the sign digit at 0000, the end-of-cycle pulse repeats every N = 4550 + (10*units + tenths) clocks.
- R2: With any non-zero sign digit, the end-of-cycle pulse repeats every N = 4550 - (10*units + tenths) clocks.
- R3: The units and tenths digits are read as straight BCD, and any value above 9 counts as 9. The counter digits never hold a value above 9.
- R4: Each end-of-cycle pulse is high for exactly one clock.
- R5: A thumbwheel change in the middle of a cycle leaves the length of that cycle unchanged. The change first applies to the cycle that starts at the next end-of-cycle.
- R6: The BFO output is high for 5 clocks and then low for 5 clocks, continuously.
- R7: A reference pulse that comes before the divider pulse raises pumpUp from the clock after the reference is sampled. pumpUp stays high until the clock after the divider pulse, so it is high for (lead + 1) clocks. pumpUp and pumpDown are never high together.
- R8: A divider pulse that comes d clocks before the reference pulse holds pumpDown high for d clocks.
- R9: A reference pulse sampled on the same edge at which the comparator sees the divider pulse raises neither pump flag.
- R10: While reset is high, eocPulse, bfoOut, pumpUp and pumpDown are low. The first end-of-cycle pulse appears on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Squared-up VCO clock |
| rst | input | 1 | Synchronous active-high reset |
| signDigit | input | 4 | Sign thumbwheel digit: 0000 means plus, any other value means minus |
| unitsDigit | input | 4 | Units-of-kHz offset digit (BCD) |
| tenthsDigit | input | 4 | Tenths-of-kHz offset digit (BCD) |
| refPulse | input | 1 | One-clock pulse from the fixed 1 kHz reference |
| eocPulse | output | 1 | Registered end-of-cycle pulse, once per N clocks |
| bfoOut | output | 1 | VCO clock divided by 10, 50% duty cycle |
| pumpUp | output | 1 | Comparator flag: the divider lags the reference |
| pumpDown | output | 1 | Comparator flag: the divider leads the reference |

## Verification
The assertions check every cycle that the end-of-cycle pulse is one clock wide and follows only a counter that has reached zero. They also check that every counter digit stays legal BCD, that the BFO output never changes level on two clocks in a row, and that the two pump flags are never high together. Only the bench scenarios can show the exact cycle lengths for each sign and digit setting, the clamping of digits above 9, and that a change in mid-cycle is deferred to the next boundary. The same holds for the exact pump pulse widths for a reference that leads, lags or coincides with the divider pulse.

// File: rtl/bfoPkg.sv
package bfoPkg;
  localparam int DefDigits = 4;
  localparam int DefCenter = 4550;
  localparam int DefBfoDiv = 10;
  localparam int DigitW    = 4;

  // strobes from control to the digit-counter datapath
  typedef struct packed {
    logic reload;   // preset every digit stage this cycle
    logic countEn;  // decrement the chain this cycle
  } divStrobe_t;
endpackage

// File: rtl/bfoDivDatapath.sv
module bfoDivDatapath
  import bfoPkg::*;
#(
  parameter int Digits = DefDigits,
  parameter int Center = DefCenter
) (
  input  logic                    clk,
  input  logic                    rst,
  input  divStrobe_t              strobe,
  input  logic [DigitW-1:0]       signDigit,
  input  logic [DigitW-1:0]       unitsDigit,
  input  logic [DigitW-1:0]       tenthsDigit,
  output logic                    termFlag,
  output logic [Digits*DigitW-1:0] cntFlat
);
  localparam int BinW = $clog2(10 ** Digits) + 1;

  logic [DigitW-1:0] unitsC, tenthsC;
  logic              minusSel;
  logic [BinW-1:0]   offBin, targetBin;
  logic [Digits*DigitW-1:0] presetFlat;
  logic [Digits:0]   borrow;

  // offset around the centre; the preset value is N-1 so a full cycle is N clocks
  always_comb begin
    unitsC    = (unitsDigit  > 4'd9) ? 4'd9 : unitsDigit;
    tenthsC   = (tenthsDigit > 4'd9) ? 4'd9 : tenthsDigit;
    minusSel  = |signDigit;
    offBin    = BinW'(unitsC) * BinW'(10) + BinW'(tenthsC);
    targetBin = minusSel ? (BinW'(Center - 1) - offBin) : (BinW'(Center - 1) + offBin);
  end

  // binary target split into BCD digits, least significant first
  always_comb begin
    logic [BinW-1:0] rem;
    rem = targetBin;
    presetFlat = '0;
    for (int i = 0; i < Digits; i++) begin
      presetFlat[i*DigitW +: DigitW] = DigitW'(rem % BinW'(10));
      rem = rem / BinW'(10);
    end
  end

  assign borrow[0] = strobe.countEn;

  generate
    for (genvar g = 0; g < Digits; g++) begin : gDigit
      logic [DigitW-1:0] digQ;
      always_ff @(posedge clk) begin
        if (rst) begin
          digQ <= '0;
        end else if (strobe.reload) begin
          digQ <= presetFlat[g*DigitW +: DigitW];
        end else if (borrow[g]) begin
          digQ <= (digQ == '0) ? 4'd9 : digQ - 4'd1;
        end
      end
      assign borrow[g+1] = borrow[g] && (digQ == '0);
      assign cntFlat[g*DigitW +: DigitW] = digQ;
    end
  endgenerate

  assign termFlag = (cntFlat == '0);
endmodule

// File: rtl/bfoDivCtrl.sv
module bfoDivCtrl
  import bfoPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       termFlag,
  output divStrobe_t strobe,
  output logic       eocPulse
);
  logic eocQ;

  always_comb begin
    strobe.reload  = termFlag;
    strobe.countEn = !termFlag;
  end

  // registered so the pulse is glitch free and exactly one clock wide
  always_ff @(posedge clk) begin
    if (rst) eocQ <= 1'b0;
    else     eocQ <= termFlag;
  end

  assign eocPulse = eocQ;
endmodule

// File: rtl/bfoJohnsonDiv.sv
module bfoJohnsonDiv #(
  parameter int BfoDiv = bfoPkg::DefBfoDiv
) (
  input  logic clk,
  input  logic rst,
  output logic bfoOut
);
  localparam int JohnW = BfoDiv / 2;

  logic [JohnW-1:0] johnQ;

  always_ff @(posedge clk) begin
    if (rst) johnQ <= '0;
    else     johnQ <= {johnQ[JohnW-2:0], ~johnQ[JohnW-1]};
  end

  assign bfoOut = johnQ[JohnW-1];
endmodule

// File: rtl/bfoPhaseComp.sv
module bfoPhaseComp (
  input  logic clk,
  input  logic rst,
  input  logic refPulse,
  input  logic divPulse,
  output logic pumpUp,
  output logic pumpDown
);
  logic upQ, dnQ, upNext, dnNext;

  always_comb begin
    upNext = upQ | refPulse;
    dnNext = dnQ | divPulse;
    if (upNext && dnNext) begin
      upNext = 1'b0;
      dnNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      upQ <= upNext;
      dnQ <= dnNext;
    end
  end

  assign pumpUp   = upQ;
  assign pumpDown = dnQ;
endmodule

// File: rtl/bfoDivider.sv
module bfoDivider
  import bfoPkg::*;
#(
  parameter int Digits = DefDigits,
  parameter int Center = DefCenter,
  parameter int BfoDiv = DefBfoDiv
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] signDigit,
  input  logic [3:0] unitsDigit,
  input  logic [3:0] tenthsDigit,
  input  logic       refPulse,
  output logic       eocPulse,
  output logic       bfoOut,
  output logic       pumpUp,
  output logic       pumpDown
);
  divStrobe_t strobe;
  logic       termFlag;
  logic [Digits*DigitW-1:0] countBus;

  bfoDivCtrl uCtrl (
    .clk(clk), .rst(rst), .termFlag(termFlag), .strobe(strobe), .eocPulse(eocPulse)
  );

  bfoDivDatapath #(.Digits(Digits), .Center(Center)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .signDigit(signDigit), .unitsDigit(unitsDigit), .tenthsDigit(tenthsDigit),
    .termFlag(termFlag), .cntFlat(countBus)
  );

  bfoJohnsonDiv #(.BfoDiv(BfoDiv)) uBfo (
    .clk(clk), .rst(rst), .bfoOut(bfoOut)
  );

  bfoPhaseComp uPfd (
    .clk(clk), .rst(rst), .refPulse(refPulse), .divPulse(eocPulse),
    .pumpUp(pumpUp), .pumpDown(pumpDown)
  );
endmodule

// File: rtl/bfoDividerChecker.sv
module bfoDividerChecker #(
  parameter int Digits = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  eocPulse,
  input logic                  bfoOut,
  input logic                  pumpUp,
  input logic                  pumpDown,
  input logic [Digits*4-1:0]   countBus
);
  a_r4_eoc_one_cycle: assert property (@(posedge clk) disable iff (rst)
    eocPulse |=> !eocPulse);

  a_r1_eoc_after_zero: assert property (@(posedge clk) disable iff (rst)
    eocPulse |-> ($past(countBus) == '0));

  a_r7_no_both_pumps: assert property (@(posedge clk) disable iff (rst)
    !(pumpUp && pumpDown));

  a_r6_bfo_hold: assert property (@(posedge clk) disable iff (rst)
    (bfoOut != $past(bfoOut)) |=> $stable(bfoOut));

  generate
    for (genvar g = 0; g < Digits; g++) begin : gBcd
      a_r3_digit_bcd: assert property (@(posedge clk) disable iff (rst)
        countBus[g*4 +: 4] <= 4'd9);
    end
  endgenerate
endmodule

bind bfoDivider bfoDividerChecker #(.Digits(Digits)) uChk (
  .clk(clk), .rst(rst), .eocPulse(eocPulse), .bfoOut(bfoOut),
  .pumpUp(pumpUp), .pumpDown(pumpDown), .countBus(countBus)
);

// File: tb/bfoDivider_test.sv
module bfoDivider_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] signDigit, unitsDigit, tenthsDigit;
  logic refPulse;
  logic eocPulse, bfoOut, pumpUp, pumpDown;

  bfoDivider uut (
    .clk(clk), .rst(rst), .signDigit(signDigit), .unitsDigit(unitsDigit),
    .tenthsDigit(tenthsDigit), .refPulse(refPulse), .eocPulse(eocPulse),
    .bfoOut(bfoOut), .pumpUp(pumpUp), .pumpDown(pumpDown)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    int    n;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int  total = 0;
  int  bad = 0;
  int  cycleCnt = 0;
  bit  monitorOn = 1'b0;
  int  gap = 0;
  bit  seenEoc = 1'b0;
  bit  prevEoc = 1'b0;
  int  runLen = 0;
  bit  runSeen = 1'b0;
  logic prevBfo = 1'b0;
  expItem_t popped;

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // ratio from the requirements (R1, R2, R3)
  function automatic int expN(logic [3:0] s, logic [3:0] u, logic [3:0] t);
    int uc = (u > 9) ? 9 : int'(u);
    int tc = (t > 9) ? 9 : int'(t);
    int off = uc * 10 + tc;
    return (s == 4'd0) ? 4550 + off : 4550 - off;
  endfunction

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 150000) begin
      check(1'b0, "watchdog", cycleCnt, 150000);
      finishRun();
    end
  end

  // monitor: cycle lengths (scoreboard), pulse width, BFO runs
  always @(negedge clk) begin
    if (!rst) begin
      if (eocPulse) check(!prevEoc, "R4", prevEoc ? 2 : 1, 1);
      prevEoc = eocPulse;
      if (monitorOn) begin
        if (eocPulse) begin
          if (seenEoc) begin
            if (expQ.size() == 0) check(1'b0, "R1 empty queue", gap + 1, 0);
            else begin
              popped = expQ.pop_front();
              check(gap + 1 == popped.n, popped.tag, gap + 1, popped.n);
            end
          end
          seenEoc = 1'b1;
          gap = 0;
        end else begin
          gap++;
        end
      end
      if (bfoOut == prevBfo) runLen++;
      else begin
        if (runSeen) check(runLen == 5, "R6", runLen, 5);
        runSeen = 1'b1;
        runLen = 1;
      end
      prevBfo = bfoOut;
    end
  end

  // driver: called at an end-of-cycle sample; queues the cycle just loaded
  task automatic pushApply(string tag, logic [3:0] s, logic [3:0] u, logic [3:0] t, int delay);
    expItem_t it;
    it.n = expN(signDigit, unitsDigit, tenthsDigit);
    it.tag = tag;
    expQ.push_back(it);
    repeat (delay) @(negedge clk);
    signDigit = s;
    unitsDigit = u;
    tenthsDigit = t;
    do @(negedge clk); while (!eocPulse);
  endtask

  task automatic pfdPhase();
    int n = expN(signDigit, unitsDigit, tenthsDigit);
    int dA = 7;
    int dB = 20;
    int upA = 0, dnA = 0, upB = 0, dnB = 0, upC = 0, dnC = 0;
    do @(negedge clk); while (!eocPulse);
    for (int k = 1; k <= 2 * n + 3; k++) begin
      @(negedge clk);
      if (k <= dA + 3) begin
        upA += int'(pumpUp); dnA += int'(pumpDown);
      end else if (k <= n + 3) begin
        upB += int'(pumpUp); dnB += int'(pumpDown);
      end else begin
        upC += int'(pumpUp); dnC += int'(pumpDown);
      end
      refPulse = (k == dA) || (k == n - dB - 1) || (k == 2 * n);
    end
    refPulse = 1'b0;
    check(dnA == dA, "R8 pumpDown width", dnA, dA);
    check(upA == 0, "R8 pumpUp idle", upA, 0);
    check(upB == dB + 1, "R7 pumpUp width", upB, dB + 1);
    check(dnB == 0, "R7 pumpDown idle", dnB, 0);
    check(upC == 0, "R9 pumpUp", upC, 0);
    check(dnC == 0, "R9 pumpDown", dnC, 0);
  endtask

  initial begin
    signDigit = 4'd0; unitsDigit = 4'd5; tenthsDigit = 4'd4;
    refPulse = 1'b0;
    rst = 1'b1;
    monitorOn = 1'b1;
    repeat (3) @(negedge clk);
    check(eocPulse == 1'b0, "R10 eoc in reset", int'(eocPulse), 0);
    check(bfoOut == 1'b0, "R10 bfo in reset", int'(bfoOut), 0);
    check(pumpUp == 1'b0, "R10 up in reset", int'(pumpUp), 0);
    check(pumpDown == 1'b0, "R10 down in reset", int'(pumpDown), 0);
    rst = 1'b0;
    @(negedge clk);
    check(eocPulse == 1'b1, "R10 first eoc", int'(eocPulse), 1);

    pushApply("R1 +5.4", 4'd0, 4'd0, 4'd0, 0);
    pushApply("R1 +0.0", 4'd1, 4'd5, 4'd4, 0);
    pushApply("R5 -5.4 changed mid-cycle", 4'd0, 4'd9, 4'd9, 2000);
    pushApply("R5 +9.9 changed late", 4'd1, 4'd9, 4'd9, 4000);
    pushApply("R2 -9.9", 4'd8, 4'd1, 4'd2, 100);
    pushApply("R2 other minus code", 4'd0, 4'd12, 4'd15, 0);
    pushApply("R3 clamped digits", 4'd1, 4'd0, 4'd7, 0);
    pushApply("R2 -0.7", 4'd0, 4'd5, 4'd4, 0);
    pushApply("R1 +5.4 again", 4'd0, 4'd5, 4'd4, 0);
    @(negedge clk);
    monitorOn = 1'b0;
    check(expQ.size() == 0, "R1 all cycles seen", expQ.size(), 0);

    pfdPhase();
    finishRun();
  end
endmodule